// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block turns host requests into strobe sequences for an asynchronous DRAM. Each request names a row, a starting column, a beat count and a direction. The sequencer lowers the row strobe once to latch the row. It then keeps the row strobe low and pulses the column strobe once per beat. Before each column pulse it moves the address bus to the next column. Only the first beat pays the row-to-column delay. Every later beat in the same page costs one column pulse plus one column precharge.

All timing is set by parameters given in clock cycles: the row-to-column delay, the width of the column pulse, the column precharge, the row precharge, the longest time the row strobe may stay low, and the read sampling latency. A burst that would hold the row strobe low for too long is split. The page closes after the beat that still fits, the row precharges, and the same row reopens to finish the remaining columns. Read data comes back one word per beat with a one-cycle valid strobe. Write data is taken one word per beat under an acknowledge strobe.

Top module: `dram_page_seq`

## Requirements
- R1: While reset is applied, ras_n, cas_n and we_n are high, dq_oe and rd_valid are low, and req_ready is high.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. ras_n falls at that edge. During the first cycle that ras_n is low, dram_addr carries the row, zero-extended.
- R3: In the second cycle that ras_n is low, dram_addr carries the start column. cas_n first falls T_RCD cycles after ras_n falls, so the first low cycle of cas_n is cycle T_RCD+1 of the row-strobe-low period.
- R4: Each beat holds cas_n low for exactly T_CAS cycles. Between beats inside one page, cas_n stays high for exactly T_CP cycles while ras_n stays low. Beat k of a request uses column start+k (modulo 2^COL_W), and that column is on dram_addr when cas_n falls.
- R5: A request with req_len = L performs exactly L+1 beats. After the last beat, ras_n rises at the same edge as cas_n.
- R6: Once ras_n rises, it stays high for at least T_RP cycles before it falls again. req_ready is high only while both strobes are high.
- R7: ras_n is never low for more than T_RASMAX consecutive cycles. If another T_CP+T_CAS cycles would exceed that limit, the page closes after the current beat, precharges for T_RP cycles, and reopens the same row at the next column. With the bench parameters, a page holds at most 4 beats.
- R8: For a read beat, dq_in is sampled at the RD_LAT-th clock edge after cas_n falls. The sampled word appears on rd_data with rd_valid high for exactly one cycle.
- R9: For a write, wr_ack is high for one cycle just before each fall of cas_n. The wr_data word present in that cycle is driven on dq_out, with dq_oe high and we_n low, while cas_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken this cycle if valid |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | First column of the burst |
| req_len | input | LEN_W | Beats minus one |
| req_we | input | 1 | 1 = write burst, 0 = read burst |
| wr_data | input | DW | Write word for the current beat |
| wr_ack | output | 1 | wr_data is taken at the end of this cycle |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | rd_data valid, one cycle per read beat |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | DW | Data driven to the memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DW | Data returned by the memory |

## Verification
The end of a burst and the limit on row-strobe-low time can both close the page at the end of the same beat. A 4-beat read is chosen so that its last beat is also the last one that fits under T_RASMAX. It must produce exactly one row cycle and no empty reopen. Bursts of 5 and 16 beats then force true splits, and the bench counts the row-strobe falls of each request against the count implied by R7. In the same burst, a read sample lands on the edge where cas_n rises, because RD_LAT equals T_CAS. The memory model varies its data with each column-low cycle, so sampling one cycle early or late shows up as a value mismatch.

// File: rtl/dps_pkg.sv
package dps_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RCD,
        S_CAS,
        S_CP,
        S_RP
    } dps_state_e;
endpackage

// File: rtl/dps_ras_guard.sv
module dps_ras_guard #(
    parameter int T_RASMAX = 20,
    parameter int CONT     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic fits_more
);
    localparam int W = $clog2(T_RASMAX + CONT + 2) + 1;

    logic [W-1:0] run_q, run_d, run_len;

    always_comb begin
        run_len   = ras_low ? run_q + W'(1) : '0;
        run_d     = run_len;
        fits_more = (run_len + W'(CONT)) <= W'(T_RASMAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R7: row strobe low time never exceeds the limit
    p_ras_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (run_len <= W'(T_RASMAX)));
endmodule

// File: rtl/dps_rd_capture.sv
module dps_rd_capture #(
    parameter int DW     = 16,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } cap_t;

    cap_t cap_q, cap_d;
    logic take;

    generate
        if (RD_LAT <= 1) begin : g_direct
            assign take = launch;
        end else begin : g_pipe
            logic [RD_LAT-2:0] sr_q, sr_d;
            always_comb begin
                sr_d = {sr_q, launch};
            end
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= sr_d;
            end
            assign take = sr_q[RD_LAT-2];
        end
    endgenerate

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = take;
        if (take) cap_d.data = dq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.vld;

    // R8: valid is a single-cycle pulse per beat
    p_rdv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
    import dps_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int COL_W    = 8,
    parameter int DW       = 16,
    parameter int LEN_W    = 4,
    parameter int T_RCD    = 3,
    parameter int T_CAS    = 2,
    parameter int T_CP     = 2,
    parameter int T_RP     = 3,
    parameter int T_RASMAX = 20,
    parameter int RD_LAT   = 2,
    localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_we,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_ack,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [AW-1:0]    dram_addr,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    input  logic [DW-1:0]    dq_in
);
    localparam int TM1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TM2 = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int TMX = (TM1 > TM2) ? TM1 : TM2;
    localparam int CW  = $clog2(TMX + 1) + 1;

    typedef struct packed {
        dps_state_e       state;
        logic [CW-1:0]    cnt;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    dq;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] left;
        logic             we;
        logic             pend;
    } seq_t;

    seq_t r_q, r_d;
    logic fits_more;
    logic launch;

    dps_ras_guard #(
        .T_RASMAX(T_RASMAX),
        .CONT    (T_CP + T_CAS)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_low  (!r_q.ras_n),
        .fits_more(fits_more)
    );

    assign launch = (r_q.state == S_CAS) && (r_q.cnt == CW'(T_CAS - 1)) && !r_q.we;

    dps_rd_capture #(
        .DW    (DW),
        .RD_LAT(RD_LAT)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .dq_in   (dq_in),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.state = S_RCD;
                    r_d.ras_n = 1'b0;
                    r_d.we_n  = ~req_we;
                    r_d.addr  = AW'(req_row);
                    r_d.row   = req_row;
                    r_d.col   = req_col;
                    r_d.left  = req_len;
                    r_d.we    = req_we;
                    r_d.pend  = 1'b0;
                    r_d.cnt   = CW'(T_RCD - 1);
                end
            end
            S_RCD: begin
                r_d.addr = AW'(r_q.col);
                if (r_q.cnt == '0) begin
                    r_d.state = S_CAS;
                    r_d.cas_n = 1'b0;
                    r_d.cnt   = CW'(T_CAS - 1);
                    if (r_q.we) begin
                        r_d.dq = wr_data;
                        r_d.oe = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            S_CAS: begin
                if (r_q.cnt == '0) begin
                    r_d.cas_n = 1'b1;
                    r_d.oe    = 1'b0;
                    if (r_q.left == '0) begin
                        r_d.state = S_RP;
                        r_d.ras_n = 1'b1;
                        r_d.we_n  = 1'b1;
                        r_d.pend  = 1'b0;
                        r_d.cnt   = CW'(T_RP - 1);
                    end else begin
                        r_d.left = r_q.left - LEN_W'(1);
                        r_d.col  = r_q.col + COL_W'(1);
                        if (fits_more) begin
                            r_d.state = S_CP;
                            r_d.addr  = AW'(r_q.col + COL_W'(1));
                            r_d.cnt   = CW'(T_CP - 1);
                        end else begin
                            r_d.state = S_RP;
                            r_d.ras_n = 1'b1;
                            r_d.we_n  = 1'b1;
                            r_d.pend  = 1'b1;
                            r_d.cnt   = CW'(T_RP - 1);
                        end
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            S_CP: begin
                if (r_q.cnt == '0) begin
                    r_d.state = S_CAS;
                    r_d.cas_n = 1'b0;
                    r_d.cnt   = CW'(T_CAS - 1);
                    if (r_q.we) begin
                        r_d.dq = wr_data;
                        r_d.oe = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            S_RP: begin
                if (r_q.cnt == '0) begin
                    if (r_q.pend) begin
                        r_d.state = S_RCD;
                        r_d.ras_n = 1'b0;
                        r_d.we_n  = ~r_q.we;
                        r_d.addr  = AW'(r_q.row);
                        r_d.pend  = 1'b0;
                        r_d.cnt   = CW'(T_RCD - 1);
                    end else begin
                        r_d.state = S_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
            r_q.ras_n <= 1'b1;
            r_q.cas_n <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == S_IDLE);
    assign wr_ack    = r_q.we && ((r_q.state == S_RCD) || (r_q.state == S_CP)) && (r_q.cnt == '0);
    assign ras_n     = r_q.ras_n;
    assign cas_n     = r_q.cas_n;
    assign we_n      = r_q.we_n;
    assign dram_addr = r_q.addr;
    assign dq_out    = r_q.dq;
    assign dq_oe     = r_q.oe;

    // R4: column strobe only pulses inside an open row
    p_cas_in_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    // R9: a write acknowledge is followed by a column strobe fall
    p_wack_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> $fell(cas_n) && dq_oe && !we_n);
    // R6: ready only with both strobes inactive
    p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && cas_n));
    // R2: the row is on the bus as the row strobe falls
    p_row_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (dram_addr == AW'(r_q.row)));
    // R5: row strobe never rises while a column pulse is active
    p_ras_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);
endmodule

// File: tb/tb_dram_page_seq.sv
module tb_dram_page_seq;
    localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 3, T_RASMAX = 20, RD_LAT = 2;

    typedef struct packed {
        logic        we;
        logic [7:0]  row;
        logic [7:0]  col;
        logic [15:0] data;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0] req_row = '0;
    logic [7:0] req_col = '0;
    logic [3:0] req_len = '0;
    logic req_we = 1'b0;
    logic [15:0] wr_data;
    logic wr_ack;
    logic [15:0] rd_data;
    logic rd_valid;
    logic ras_n, cas_n, we_n, dq_oe;
    logic [7:0] dram_addr;
    logic [15:0] dq_out;
    logic [15:0] dq_in = '0;

    logic [15:0] wmem [0:255];
    int wput = 0;
    int widx = 0;
    assign wr_data = wmem[widx[7:0]];

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int ras_cycles = 0;

    beat_t sbq[$];
    logic [15:0] rdq[$];

    always #10 clk = ~clk;

    dram_page_seq #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
        .T_RASMAX(T_RASMAX), .RD_LAT(RD_LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_we(req_we),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_data(rd_data), .rd_valid(rd_valid),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dram_addr(dram_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    function automatic logic [15:0] pat(input logic [7:0] r, input logic [7:0] c);
        return {r, c} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (wr_ack) widx <= widx + 1;

    // monitor / memory model
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    int ras_low = 0, ras_high = 100, cas_low = 0, cas_high = 100, since = 0;
    bit first = 1'b0;
    logic [7:0] cur_row = '0, cur_col = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (rdq.size() == 0) chk(1'b0, "R8 spurious", {16'h0, rd_data}, 32'h0);
                else begin
                    logic [15:0] e;
                    e = rdq.pop_front();
                    chk(rd_data == e, "R8 read data", {16'h0, rd_data}, {16'h0, e});
                end
            end
            if (prev_ras && !ras_n) begin
                chk(ras_high >= T_RP, "R6 row precharge", ras_high, T_RP);
                if (sbq.size() > 0) chk(dram_addr == sbq[0].row, "R2 row address", dram_addr, sbq[0].row);
                cur_row = dram_addr;
                since = 1;
                first = 1'b1;
                ras_cycles++;
            end else if (!ras_n) begin
                since++;
            end
            if (!prev_ras && ras_n) begin
                chk(ras_low <= T_RASMAX, "R7 row low time", ras_low, T_RASMAX);
                chk(cas_n == 1'b1, "R5 strobes rise together", cas_n, 1);
            end
            if (!ras_n && since == 2 && first && sbq.size() > 0)
                chk(dram_addr == sbq[0].col, "R3 column switch", dram_addr, sbq[0].col);
            if (prev_cas && !cas_n) begin
                if (first) chk(since == T_RCD + 1, "R3 row to column delay", since, T_RCD + 1);
                else       chk(cas_high == T_CP, "R4 column precharge", cas_high, T_CP);
                first = 1'b0;
                cur_col = dram_addr;
                if (sbq.size() == 0) chk(1'b0, "R5 extra beat", dram_addr, 0);
                else begin
                    beat_t b;
                    b = sbq.pop_front();
                    chk(dram_addr == b.col, "R4 column address", dram_addr, b.col);
                    chk(cur_row == b.row, "R2 open row", cur_row, b.row);
                    if (b.we) chk(!we_n && dq_oe && dq_out == b.data, "R9 write beat",
                                  {we_n, dq_oe, dq_out}, {2'b01, b.data});
                    else begin
                        chk(we_n && !dq_oe, "R8 read strobes", {we_n, dq_oe}, 2'b10);
                        rdq.push_back(pat(cur_row, cur_col) ^ 16'(RD_LAT));
                    end
                end
            end
            if (!prev_cas && cas_n) chk(cas_low == T_CAS, "R4 column pulse width", cas_low, T_CAS);
            if (ras_n) begin ras_high = prev_ras ? ras_high + 1 : 1; end
            else       begin ras_low  = prev_ras ? 1 : ras_low + 1; end
            if (cas_n) begin cas_high = prev_cas ? cas_high + 1 : 1; end
            else       begin cas_low  = prev_cas ? 1 : cas_low + 1; end
            dq_in = cas_n ? 16'h0 : (pat(cur_row, cur_col) ^ 16'(cas_low));
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic do_req(input logic [7:0] row, input logic [7:0] col, input int beats,
                          input logic we, input int exp_ras);
        int r0;
        for (int k = 0; k < beats; k++) begin
            beat_t b;
            b.we = we;
            b.row = row;
            b.col = col + 8'(k);
            b.data = 16'hC000 ^ {row, col} ^ 16'(k * 37);
            if (we) begin
                wmem[wput[7:0]] = b.data;
                wput++;
            end
            sbq.push_back(b);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = ras_cycles;
        req_row = row; req_col = col; req_len = 4'(beats - 1); req_we = we;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R5 beat count", sbq.size(), 0);
        chk(rdq.size() == 0, "R8 reads returned", rdq.size(), 0);
        chk(ras_cycles - r0 == exp_ras, "R7 row cycles per request", ras_cycles - r0, exp_ras);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n && !dq_oe && !rd_valid && req_ready, "R1 reset state",
            {ras_n, cas_n, we_n, dq_oe, rd_valid, req_ready}, 6'b111001);
        rst_n = 1'b1;
        do_req(8'h12, 8'h34, 1, 1'b0, 1);
        do_req(8'h21, 8'h10, 3, 1'b1, 1);
        do_req(8'h21, 8'h40, 4, 1'b0, 1);   // length and row limit coincide
        do_req(8'h33, 8'h80, 5, 1'b0, 2);
        do_req(8'h44, 8'hFC, 16, 1'b1, 4);  // column wrap and splits
        do_req(8'h7E, 8'h00, 2, 1'b0, 1);
        do_req(8'h7E, 8'h02, 1, 1'b1, 1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule